// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Cache

This block answers 32-bit word reads that land in a memory-mapped window onto serial flash. It keeps a single 1024-byte line. The line starts at the bus address of the request that last missed, and that address need not be aligned. A read that falls inside the line is answered in the same cycle from the stored copy. A read outside the line stalls the requester while the block refills the line. To refill, it drives one chip select low and sends a command header built from a configuration word. It then streams 1024 zero bytes and keeps the bytes that come back.

The serial shifting is done by a separate byte engine. The block talks to it through a one-byte-at-a-time handshake: the block holds a byte on `xfer_tx` with `xfer_valid` high, and the engine returns the received byte together with a one-cycle `xfer_done`. Requesters hold `rd_valid` and `rd_addr` steady until `rd_ready` is seen high. Only 4-byte word reads are served.

Top module: `flash_rd_cache`

## Requirements
- R1: After reset, every chip select is high and no byte transfer is requested. The line holds nothing valid, so the first read always misses.
- R2: A read hits when its address is at least the line base and at most base + 1020. A hit is answered in the cycle it is presented: `rd_ready` goes high together with `rd_valid`. An address of base + 1021 or above, or below the base, misses.
- R3: A hit returns the stored word with index (address − base) / 4. Each stored word packs four consecutive received bytes, with the first one in bits 7:0.
- R4: On a miss, the flash address is the bus address divided by the bus count. The bus count is 2 when configuration bit 30 is set and 1 otherwise. The chip index is the flash address shifted right by 24. Only that chip's select (`flash_cs_n[index]`) is low from the first header byte to the last fill byte. All selects are high again after the fill.
- R5: The header is sent in this order: the opcode from configuration bits 7:0, then flash address bits 23:16, 15:8 and 7:0. If configuration bit 25 is set, the mode byte from bits 23:16 follows. Last come N zero bytes, where N is configuration bits 10:8.
- R6: Bytes received during the header are dropped. Exactly 1024 zero bytes follow the header, and the bytes received for them fill the line in order.
- R7: After a fill, the line base is the requested bus address itself, not an aligned address.
- R8: Configuration resets to 0x03A002EB. A write strobe loads a new configuration, and the next miss uses it.
- R9: During a miss the requester sees `rd_ready` low until the fill has ended. The held request is then answered from the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration value to load |
| rd_valid | input | 1 | Word read request |
| rd_addr | input | 25 | Byte address within the window |
| rd_ready | output | 1 | Read accepted, data valid this cycle |
| rd_data | output | 32 | Returned word |
| flash_cs_n | output | 2 | Active-low chip selects |
| xfer_valid | output | 1 | Byte transfer requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Byte exchanged this cycle |
| xfer_rx | input | 8 | Byte received |

## Verification
If the line base or valid flag is corrupted, a read near a line edge is answered at once when it should stall, or stalls when it should be answered. This shows on `rd_ready` in the very cycle the request is presented. If the fill counter or the packing is off, the wrong word comes back on the first hit after the fill. It also changes the number of bytes exchanged before the selects rise, which the bench counts on every handshake. A wrong header field or chip choice appears on the first `xfer_tx` byte or `flash_cs_n` level of the miss.

// File: rtl/frc_pkg.sv
package frc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_FILL = 2'd2
   } frc_state_e;

   localparam logic [31:0] CFG_RESET_VAL = 32'h03A0_02EB;
   localparam int CFG_DUAL_BIT  = 30;
   localparam int CFG_MODE_BIT  = 25;
   localparam int FLASH_AW      = 24;
   localparam int HDR_MAX_BYTES = 12;
endpackage

// File: rtl/frc_hdr_seq.sv
module frc_hdr_seq #(
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [7:0]        op_in,
   input  logic [7:0]        mode_in,
   input  logic              mode_en_in,
   input  logic [2:0]        dummy_in,
   input  logic [23:0]       faddr_in,
   output logic [7:0]        hdr_byte,
   output logic              hdr_last
);
   import frc_pkg::*;

   if ((2 ** IDX_W) < HDR_MAX_BYTES) begin : g_bad_idx
      $error("frc_hdr_seq: IDX_W too small for the longest header");
   end

   logic [7:0]       op_q, mode_q;
   logic [23:0]      addr_q;
   logic             mode_en_q;
   logic [IDX_W-1:0] idx_q, last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q      <= '0;
         mode_q    <= '0;
         addr_q    <= '0;
         mode_en_q <= 1'b0;
         idx_q     <= '0;
         last_q    <= '0;
      end else if (load) begin
         op_q      <= op_in;
         mode_q    <= mode_in;
         addr_q    <= faddr_in;
         mode_en_q <= mode_en_in;
         idx_q     <= '0;
         last_q    <= IDX_W'(3) + IDX_W'(mode_en_in) + IDX_W'(dummy_in);
      end else if (step && !hdr_last) begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   always_comb begin
      case (idx_q)
         IDX_W'(0): hdr_byte = op_q;
         IDX_W'(1): hdr_byte = addr_q[23:16];
         IDX_W'(2): hdr_byte = addr_q[15:8];
         IDX_W'(3): hdr_byte = addr_q[7:0];
         IDX_W'(4): hdr_byte = mode_en_q ? mode_q : 8'h00;
         default:   hdr_byte = 8'h00;
      endcase
   end

   assign hdr_last = (idx_q == last_q);

   // header never runs past its computed length
   assert_hdr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_W'(HDR_MAX_BYTES - 1));
endmodule

// File: rtl/frc_line_buf.sv
module frc_line_buf #(
   parameter int ADDR_W     = 25,
   parameter int LINE_BYTES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [7:0]        wr_byte,
   input  logic              commit,
   input  logic [ADDR_W-1:0] commit_base,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              hit,
   output logic [31:0]       rd_word,
   output logic              fill_last
);
   localparam int WORDS  = LINE_BYTES / 4;
   localparam int WIDX_W = $clog2(WORDS);
   localparam int CNT_W  = $clog2(LINE_BYTES);
   localparam int DW     = ADDR_W + 1;

   if (DW <= WIDX_W + 2) begin : g_bad_aw
      $error("frc_line_buf: address too narrow for the line size");
   end

   logic [31:0]       mem [WORDS];
   logic [CNT_W-1:0]  cnt_q;
   logic [23:0]       pack_q;
   logic              valid_q;
   logic [ADDR_W-1:0] base_q;
   logic [DW-1:0]     diff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pack_q  <= '0;
         valid_q <= 1'b0;
         base_q  <= '1;
      end else begin
         if (clear) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
         end else if (wr_en) begin
            cnt_q  <= cnt_q + CNT_W'(1);
            pack_q <= {wr_byte, pack_q[23:8]};
         end
         if (commit) begin
            valid_q <= 1'b1;
            base_q  <= commit_base;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && (cnt_q[1:0] == 2'd3))
         mem[cnt_q[CNT_W-1:2]] <= {wr_byte, pack_q};
   end

   assign fill_last = (cnt_q == CNT_W'(LINE_BYTES - 1));
   assign diff      = {1'b0, lk_addr} - {1'b0, base_q};
   assign hit       = valid_q && (lk_addr >= base_q) && (diff <= DW'(LINE_BYTES - 4));
   assign rd_word   = mem[diff[WIDX_W+1:2]];

   // the base latched after a fill is the exact requested address
   assert_commit_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (valid_q && base_q == $past(commit_base)));
endmodule

// File: rtl/frc_cs_dec.sv
module frc_cs_dec #(
   parameter int CHIP_W = 1,
   parameter int NUM_CS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_en,
   input  logic              release_all,
   input  logic [CHIP_W-1:0] chip,
   output logic [NUM_CS-1:0] cs_n
);
   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      logic cs_bit;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cs_bit <= 1'b1;
         else if (sel_en)
            cs_bit <= (chip != CHIP_W'(g));
         else if (release_all)
            cs_bit <= 1'b1;
      end
      assign cs_n[g] = cs_bit;
   end

   assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
endmodule

// File: rtl/flash_rd_cache.sv
module flash_rd_cache #(
   parameter int          ADDR_W     = 25,
   parameter int          LINE_BYTES = 1024,
   parameter int          MAX_BUSES  = 2,
   parameter logic [31:0] CFG_RESET  = frc_pkg::CFG_RESET_VAL
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_we,
   input  logic [31:0]                         cfg_wdata,
   input  logic                                rd_valid,
   input  logic [ADDR_W-1:0]                   rd_addr,
   output logic                                rd_ready,
   output logic [31:0]                         rd_data,
   output logic [(2**(ADDR_W-24))-1:0]         flash_cs_n,
   output logic                                xfer_valid,
   output logic [7:0]                          xfer_tx,
   input  logic                                xfer_done,
   input  logic [7:0]                          xfer_rx
);
   import frc_pkg::*;

   localparam int CHIP_W = ADDR_W - FLASH_AW;
   localparam int NUM_CS = 2 ** CHIP_W;

   if (CHIP_W < 1 || CHIP_W > 4) begin : g_bad_chip
      $error("flash_rd_cache: ADDR_W must be 25 to 28");
   end
   if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("flash_rd_cache: LINE_BYTES must be a power of two of at least 8");
   end
   if (MAX_BUSES < 1 || MAX_BUSES > 2) begin : g_bad_bus
      $error("flash_rd_cache: MAX_BUSES must be 1 or 2");
   end

   frc_state_e        state_q;
   logic [31:0]       cfg_q;
   logic [ADDR_W-1:0] addr_q, faddr;
   logic              dual, buf_hit, fill_last, hdr_last;
   logic              miss_start, hdr_step, fill_wr, fill_end;
   logic [7:0]        hdr_byte;
   logic              unused_cfg;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= CFG_RESET;
      else if (cfg_we)
         cfg_q <= cfg_wdata;
   end

   if (MAX_BUSES > 1) begin : g_dual
      assign dual = cfg_q[CFG_DUAL_BIT];
   end else begin : g_single
      assign dual = 1'b0;
   end

   assign unused_cfg = ^{cfg_q[31:26], cfg_q[24], cfg_q[15:11]};

   assign faddr      = dual ? {1'b0, rd_addr[ADDR_W-1:1]} : rd_addr;
   assign miss_start = (state_q == ST_IDLE) && rd_valid && !buf_hit;
   assign hdr_step   = (state_q == ST_HDR) && xfer_done;
   assign fill_wr    = (state_q == ST_FILL) && xfer_done;
   assign fill_end   = fill_wr && fill_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (miss_start) begin
               state_q <= ST_HDR;
               addr_q  <= rd_addr;
            end
            ST_HDR:  if (hdr_step && hdr_last) state_q <= ST_FILL;
            ST_FILL: if (fill_end) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   frc_hdr_seq #(.IDX_W(4)) u_hdr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (miss_start),
      .step       (hdr_step),
      .op_in      (cfg_q[7:0]),
      .mode_in    (cfg_q[23:16]),
      .mode_en_in (cfg_q[CFG_MODE_BIT]),
      .dummy_in   (cfg_q[10:8]),
      .faddr_in   (faddr[FLASH_AW-1:0]),
      .hdr_byte   (hdr_byte),
      .hdr_last   (hdr_last)
   );

   frc_line_buf #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (miss_start),
      .wr_en       (fill_wr),
      .wr_byte     (xfer_rx),
      .commit      (fill_end),
      .commit_base (addr_q),
      .lk_addr     (rd_addr),
      .hit         (buf_hit),
      .rd_word     (rd_data),
      .fill_last   (fill_last)
   );

   frc_cs_dec #(.CHIP_W(CHIP_W), .NUM_CS(NUM_CS)) u_cs (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_en      (miss_start),
      .release_all (fill_end),
      .chip        (faddr[ADDR_W-1:FLASH_AW]),
      .cs_n        (flash_cs_n)
   );

   assign xfer_valid = (state_q != ST_IDLE);
   assign xfer_tx    = (state_q == ST_HDR) ? hdr_byte : 8'h00;
   assign rd_ready   = (state_q == ST_IDLE) && rd_valid && buf_hit;

   // a miss drives exactly one select low on the next cycle
   assert_miss_selects_R4: assert property (@(posedge clk) disable iff (!rst_n)
      miss_start |=> !(&flash_cs_n));
   // no select held while idle
   assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (&flash_cs_n));
   // engine only completes bytes that were requested
   assert_done_in_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> xfer_valid);
   // the held request hits the freshly filled line
   assert_fill_then_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_end |=> (buf_hit || rd_addr != addr_q));
endmodule

// File: tb/flash_rd_cache_tb.sv
`timescale 1ns/1ps
module flash_rd_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        rd_valid = 1'b0;
   logic [24:0] rd_addr = '0;
   logic        rd_ready;
   logic [31:0] rd_data;
   logic [1:0]  flash_cs_n;
   logic        xfer_valid;
   logic [7:0]  xfer_tx;
   logic        xfer_done = 1'b0;
   logic [7:0]  xfer_rx = '0;

   always #2.5 clk = ~clk;

   flash_rd_cache u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
      .flash_cs_n(flash_cs_n), .xfer_valid(xfer_valid), .xfer_tx(xfer_tx),
      .xfer_done(xfer_done), .xfer_rx(xfer_rx)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // reference model state
   logic [31:0] m_cfg = 32'h03A0_02EB;
   bit          m_valid = 0;
   int          m_base = 0, m_chip = 0, m_fbase = 0;
   // responder state
   logic [7:0]  r_hdr [12];
   int          r_hlen = 0, r_idx = 0, r_chip = 0, r_fstart = 0, r_cyc = 0;
   logic [1:0]  r_csexp = 2'b11;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] fb(input int chip, input int a);
      return 8'((a * 37) ^ (a >>> 9) ^ (chip * 90) ^ 8'h6C);
   endfunction

   // flash responder: one byte per handshake, stalls every seventh cycle
   always @(negedge clk) begin
      xfer_done = 1'b0;
      r_cyc++;
      if (rst_n && xfer_valid && (r_cyc % 7 != 3)) begin
         if (r_idx < r_hlen) begin
            chk(xfer_tx == r_hdr[r_idx], "R5 header byte", 32'(xfer_tx), 32'(r_hdr[r_idx]));
            xfer_rx = 8'hC3;
         end else begin
            chk(xfer_tx == 8'h00, "R6 fill byte is zero", 32'(xfer_tx), 32'h0);
            xfer_rx = fb(r_chip, r_fstart + r_idx - r_hlen);
         end
         chk(flash_cs_n == r_csexp, "R4 select during transfer", 32'(flash_cs_n), 32'(r_csexp));
         r_idx++;
         xfer_done = 1'b1;
      end
   end

   // per-clock monitor: no select without a transfer
   always @(negedge clk) begin
      if (rst_n && !xfer_valid)
         chk(flash_cs_n == 2'b11, "R4 selects released when idle", 32'(flash_cs_n), 32'h3);
   end

   task automatic wr_cfg(input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      m_cfg = v;
   endtask

   task automatic rd(input int a, input string tag);
      bit hit;
      int d, fa, chip, low, idx, waitc;
      logic [31:0] exp;
      d   = a - m_base;
      hit = m_valid && (a >= m_base) && (d <= 1020);
      if (!hit) begin
         fa   = m_cfg[30] ? (a >>> 1) : a;
         chip = fa >>> 24;
         low  = fa & 32'hFF_FFFF;
         r_hdr[0] = m_cfg[7:0];
         r_hdr[1] = 8'(low >>> 16);
         r_hdr[2] = 8'(low >>> 8);
         r_hdr[3] = 8'(low);
         r_hlen = 4;
         if (m_cfg[25]) begin r_hdr[r_hlen] = m_cfg[23:16]; r_hlen++; end
         for (int k = 0; k < int'(m_cfg[10:8]); k++) begin r_hdr[r_hlen] = 8'h00; r_hlen++; end
         r_chip = chip; r_fstart = low; r_idx = 0;
         r_csexp = ~(2'b01 << chip);
      end
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = 25'(a);
      #1;
      if (hit) begin
         chk(rd_ready, {tag, " R2 hit answered at once"}, 32'(rd_ready), 32'h1);
      end else begin
         chk(!rd_ready, {tag, " R9 miss stalls"}, 32'(rd_ready), 32'h0);
         waitc = 0;
         while (!rd_ready && waitc < 4000) begin
            @(negedge clk); #1;
            waitc++;
         end
         chk(rd_ready, {tag, " R9 ready after fill"}, 32'(rd_ready), 32'h1);
         chk(r_idx == r_hlen + 1024, {tag, " R6 bytes exchanged"}, 32'(r_idx), 32'(r_hlen + 1024));
         chk(flash_cs_n == 2'b11, {tag, " R4 selects released after fill"}, 32'(flash_cs_n), 32'h3);
         m_valid = 1; m_base = a; m_chip = chip; m_fbase = low;
      end
      idx = (a - m_base) >>> 2;
      for (int j = 0; j < 4; j++) exp[8*j +: 8] = fb(m_chip, m_fbase + 4 * idx + j);
      chk(rd_data == exp, {tag, " R3 word value"}, rd_data, exp);
      @(posedge clk); #1;
      rd_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(flash_cs_n == 2'b11, "R1 selects high after reset", 32'(flash_cs_n), 32'h3);
      chk(!xfer_valid, "R1 no transfer after reset", 32'(xfer_valid), 32'h0);
      chk(!rd_ready, "R1 not ready without request", 32'(rd_ready), 32'h0);
      // R1 R8: first read misses and uses the reset configuration header
      rd(32'h0000100, "R1 R8 first read");
      rd(32'h0000104, "R2 next word");
      rd(32'h00004FC, "R2 last word of line");
      rd(32'h0000500, "R2 just past line");
      rd(32'h00004FF, "R2 below base, R7 unaligned base");
      rd(32'h0000503, "R7 unaligned hit");
      rd(32'h00008FB, "R2 unaligned upper edge");
      rd(32'h00008FC, "R2 unaligned past edge");
      rd(32'h1000010, "R4 second chip");
      rd(32'h1000018, "R3 hit on second chip");
      wr_cfg(32'h4000_070B);
      rd(32'h1800000, "R4 R8 two buses, seven dummies");
      rd(32'h1800010, "R3 hit after dual fill");
      wr_cfg(32'h0255_0103);
      rd(32'h0001234, "R5 R8 mode byte one dummy");
      rd(32'h0001630, "R2 aligned edge after new base");
      repeat (4) @(negedge clk);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule